// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the single-cycle integer execution unit of a 32-bit RISC core. From a 4-bit opcode and two operands it produces a result, a register-writeback enable and the next values of the four condition flags: negative (N), zero (Z), carry (C) and overflow (V). The operand shifter sits upstream, and this block uses only the shifter's carry-out. The register file, instruction decode and mode banking are also outside the block.

The unit supports plain and reverse subtraction and add or subtract with carry. It also has bitwise operations and four compare-style opcodes that only set flags. The set-flags bit (S) selects whether a writing opcode updates the flags. When S is set on a writing opcode whose destination is the program counter, the block does not derive flags from the result. Instead it raises a request to restore the status register from the saved status word, and it presents the saved flag bits on the flag outputs. The datapath is purely combinational and has no states. The decode step maps each opcode to an operation class: logic, add, subtract, or reverse subtract, with or without carry.

Top module: `dp_alu`

## Requirements
- R1: Logic opcodes give these results: 0 = a AND b, 1 = a XOR b, C = a OR b, D = b, E = a AND NOT b, F = NOT b. Opcode 8 uses AND and opcode 9 uses XOR for flags only.
- R2: Opcode 4 gives a+b and opcode 5 gives a+b+C. For both, C is the unsigned carry out of bit 31 of the full sum, and V is bit 31 of ((a XOR r) AND (b XOR r)). Opcode B gives a+b with the same flags.
- R3: Opcode 2 gives a−b and opcode 6 gives a−(b−C+1). Opcodes 3 and 7 give the same two results with the operands swapped. Opcode A gives a−b. C is set when the subtrahend, evaluated exactly, is not greater than the minuend, both unsigned. V is bit 31 of ((x XOR r) AND (NOT y XOR r)), where x is the minuend and y is the subtrahend operand.
- R4: Whenever the flags are updated from a result, N equals result bit 31 and Z is 1 exactly when the 32-bit result is zero.
- R5: Logic opcodes that update the flags take C from the shifter carry-out and keep V at its input value.
- R6: Opcodes 8, 9, A and B never assert writeback. Every other opcode asserts writeback.
- R7: Opcodes 8 to B update the flags whatever the values of S and the destination index.
- R8: On a writing opcode with S clear, the N/Z/C/V outputs equal the N/Z/C/V inputs.
- R9: On a writing opcode with S set and destination index 15, the restore request is 1 and N/Z/C/V equal saved-status bits 31, 30, 29 and 28. In every other case the restore request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, after the shifter |
| shc_i | input | 1 | Shifter carry-out |
| n_i | input | 1 | Current N flag |
| z_i | input | 1 | Current Z flag |
| c_i | input | 1 | Current C flag |
| v_i | input | 1 | Current V flag |
| saved_i | input | 32 | Saved status word |
| s_i | input | 1 | Set-flags bit |
| rd_i | input | 4 | Destination register index |
| res_o | output | 32 | Operation result |
| wb_o | output | 1 | Register writeback enable |
| n_o | output | 1 | Next N flag |
| z_o | output | 1 | Next Z flag |
| c_o | output | 1 | Next C flag |
| v_o | output | 1 | Next V flag |
| restore_o | output | 1 | Restore status from saved copy |

## Verification
The bench builds the unit with the default parameters: a 32-bit datapath and a 4-bit register index. With these values, index 15 is the program-counter case and the carry and overflow boundaries fall at bit 31. Random operands reach all sixteen opcodes under both settings of S. The destination index is biased toward 15 so that the restore path is exercised often. Directed cases target the all-ones operand, the most-positive signed operand, equal operands, and carry produced only by the incoming carry.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        LG_AND, LG_XOR, LG_OR, LG_PASS, LG_ANDN, LG_NOT
    } logic_fn_e;

    typedef struct packed {
        logic      arith;
        logic      sub;
        logic      swap;
        logic      use_c;
        logic      writes;
        logic      compare;
        logic_fn_e lfn;
    } ctrl_t;

endpackage

// File: rtl/dp_decode.sv
module dp_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] op_i,
    output ctrl_t      ctrl_o
);
    always_comb begin
        ctrl_o         = '0;
        ctrl_o.lfn     = LG_AND;
        ctrl_o.writes  = 1'b1;
        unique case (opcode_e'(op_i))
            OP_AND: ctrl_o.lfn = LG_AND;
            OP_EOR: ctrl_o.lfn = LG_XOR;
            OP_ORR: ctrl_o.lfn = LG_OR;
            OP_MOV: ctrl_o.lfn = LG_PASS;
            OP_BIC: ctrl_o.lfn = LG_ANDN;
            OP_MVN: ctrl_o.lfn = LG_NOT;
            OP_TST: begin ctrl_o.lfn = LG_AND; ctrl_o.writes = 1'b0; ctrl_o.compare = 1'b1; end
            OP_TEQ: begin ctrl_o.lfn = LG_XOR; ctrl_o.writes = 1'b0; ctrl_o.compare = 1'b1; end
            OP_ADD: ctrl_o.arith = 1'b1;
            OP_ADC: begin ctrl_o.arith = 1'b1; ctrl_o.use_c = 1'b1; end
            OP_SUB: begin ctrl_o.arith = 1'b1; ctrl_o.sub = 1'b1; end
            OP_RSB: begin ctrl_o.arith = 1'b1; ctrl_o.sub = 1'b1; ctrl_o.swap = 1'b1; end
            OP_SBC: begin ctrl_o.arith = 1'b1; ctrl_o.sub = 1'b1; ctrl_o.use_c = 1'b1; end
            OP_RSC: begin ctrl_o.arith = 1'b1; ctrl_o.sub = 1'b1; ctrl_o.use_c = 1'b1; ctrl_o.swap = 1'b1; end
            OP_CMP: begin ctrl_o.arith = 1'b1; ctrl_o.sub = 1'b1; ctrl_o.writes = 1'b0; ctrl_o.compare = 1'b1; end
            OP_CMN: begin ctrl_o.arith = 1'b1; ctrl_o.writes = 1'b0; ctrl_o.compare = 1'b1; end
            default: ctrl_o.lfn = LG_AND;
        endcase
    end
endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         swap_i,
    input  logic         use_c_i,
    input  logic         c_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int EW = W + 1;
    logic [W-1:0] x, y0, y, vmask;
    logic         cin;
    logic [EW-1:0] wide;

    always_comb begin
        x     = swap_i ? b_i : a_i;
        y0    = swap_i ? a_i : b_i;
        y     = sub_i ? ~y0 : y0;
        cin   = use_c_i ? c_i : sub_i;
        wide  = {1'b0, x} + {1'b0, y} + EW'(cin);
        sum_o = wide[W-1:0];
        cout_o = wide[W];
        vmask = (x ^ sum_o) & (y ^ sum_o);
        ovf_o = vmask[W-1];
    end
endmodule

// File: rtl/dp_logic.sv
module dp_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic_fn_e    fn_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (fn_i)
            LG_AND:  y_o = a_i & b_i;
            LG_XOR:  y_o = a_i ^ b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_PASS: y_o = b_i;
            LG_ANDN: y_o = a_i & ~b_i;
            LG_NOT:  y_o = ~b_i;
            default: y_o = a_i & b_i;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W      = 32,
    parameter int RIDX_W = 4
) (
    input  logic [3:0]        op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic              shc_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic              c_i,
    input  logic              v_i,
    input  logic [W-1:0]      saved_i,
    input  logic              s_i,
    input  logic [RIDX_W-1:0] rd_i,
    output logic [W-1:0]      res_o,
    output logic              wb_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o,
    output logic              v_o,
    output logic              restore_o
);
    localparam logic [RIDX_W-1:0] PC_IDX = {RIDX_W{1'b1}};

    ctrl_t        ctl;
    logic [W-1:0] arith_y, logic_y;
    logic         arith_c, arith_v;
    logic         pc_dst, upd;

    dp_decode i_dec (.op_i(op_i), .ctrl_o(ctl));

    dp_addsub #(.W(W)) i_as (
        .a_i(a_i), .b_i(b_i), .sub_i(ctl.sub), .swap_i(ctl.swap),
        .use_c_i(ctl.use_c), .c_i(c_i),
        .sum_o(arith_y), .cout_o(arith_c), .ovf_o(arith_v)
    );

    dp_logic #(.W(W)) i_lg (.fn_i(ctl.lfn), .a_i(a_i), .b_i(b_i), .y_o(logic_y));

    always_comb begin
        res_o     = ctl.arith ? arith_y : logic_y;
        wb_o      = ctl.writes;
        pc_dst    = (rd_i == PC_IDX);
        restore_o = ctl.writes & s_i & pc_dst;
        upd       = ctl.compare | (ctl.writes & s_i & ~pc_dst);
        {n_o, z_o, c_o, v_o} = {n_i, z_i, c_i, v_i};
        if (restore_o) begin
            {n_o, z_o, c_o, v_o} = saved_i[W-1:W-4];
        end else if (upd) begin
            n_o = res_o[W-1];
            z_o = (res_o == '0);
            c_o = ctl.arith ? arith_c : shc_i;
            v_o = ctl.arith ? arith_v : v_i;
        end
    end

    // R6
    always_comb begin
        wb_never_on_cmp_chk: assert (!(op_i[3:2] == 2'b10 && wb_o)) else $error("writeback on compare opcode");
    end
    // R8
    always_comb begin
        flags_hold_chk: assert (!(wb_o && !s_i) || ({n_o, z_o, c_o, v_o} == {n_i, z_i, c_i, v_i}))
            else $error("flags changed with S clear");
    end
    // R9
    always_comb begin
        restore_cond_chk: assert (!restore_o || (wb_o && s_i && rd_i == PC_IDX))
            else $error("restore without S and PC destination");
    end
    // R4
    always_comb begin
        nz_from_result_chk: assert (!(op_i[3:2] == 2'b10) || (n_o == res_o[W-1] && z_o == (res_o == '0)))
            else $error("N/Z mismatch on compare");
    end
    // R5
    always_comb begin
        logic_v_keep_chk: assert (ctl.arith || restore_o || v_o == v_i) else $error("V changed on logic op");
    end
endmodule

// File: tb/test_dp_alu.sv
module test_dp_alu;
    logic [3:0]  op;
    logic [31:0] a, b, saved, res;
    logic        shc, ni, zi, ci, vi, s, wb, no, zo, co, vo, rst_req;
    logic [3:0]  rd;
    logic        clk = 1'b0;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    dp_alu i_dp_alu (
        .op_i(op), .a_i(a), .b_i(b), .shc_i(shc), .n_i(ni), .z_i(zi), .c_i(ci), .v_i(vi),
        .saved_i(saved), .s_i(s), .rd_i(rd), .res_o(res), .wb_o(wb),
        .n_o(no), .z_o(zo), .c_o(co), .v_o(vo), .restore_o(rst_req)
    );

    function automatic string tag_of(logic [3:0] o, logic sb, logic [3:0] d);
        bit wr = !(o[3:2] == 2'b10);
        if (wr && sb && d == 4'hF) return "R9";
        if (wr && !sb) return "R8 R6";
        if (!wr) return "R6 R7 R4";
        if (o == 4'h4 || o == 4'h5) return "R2 R4";
        if (o >= 4'h2 && o <= 4'h7) return "R3 R4";
        return "R1 R4 R5";
    endfunction

    task automatic check_one();
        logic [63:0] x, y, sub64, sum64;
        logic [31:0] er;
        logic        ewb, en, ez, ec, ev, erst, upd, arith;
        logic [31:0] vm;
        ec = 1'b0; ev = 1'b0; er = '0; arith = 1'b1;
        ewb = !(op[3:2] == 2'b10);
        case (op)
            4'h0, 4'h8: begin er = a & b; arith = 1'b0; end
            4'h1, 4'h9: begin er = a ^ b; arith = 1'b0; end
            4'hC: begin er = a | b; arith = 1'b0; end
            4'hD: begin er = b; arith = 1'b0; end
            4'hE: begin er = a & ~b; arith = 1'b0; end
            4'hF: begin er = ~b; arith = 1'b0; end
            4'h4, 4'h5, 4'hB: begin
                sum64 = {32'd0, a} + {32'd0, b} + ((op == 4'h5) ? {63'd0, ci} : 64'd0);
                er = sum64[31:0]; ec = sum64[32];
                vm = (a ^ er) & (b ^ er); ev = vm[31];
            end
            default: begin
                x = (op == 4'h3 || op == 4'h7) ? {32'd0, b} : {32'd0, a};
                y = (op == 4'h3 || op == 4'h7) ? {32'd0, a} : {32'd0, b};
                sub64 = (op == 4'h6 || op == 4'h7) ? (y - {63'd0, ci} + 64'd1) : y;
                er = x[31:0] - sub64[31:0];
                ec = (sub64 <= x);
                vm = (x[31:0] ^ er) & (~y[31:0] ^ er); ev = vm[31];
            end
        endcase
        erst = ewb && s && rd == 4'hF;
        upd  = !ewb || (s && rd != 4'hF);
        {en, ez} = {ni, zi};
        if (erst) {en, ez, ec, ev} = saved[31:28];
        else if (upd) begin
            en = er[31]; ez = (er == 0);
            if (!arith) begin ec = shc; ev = vi; end
        end else {en, ez, ec, ev} = {ni, zi, ci, vi};
        total++;
        if (res !== er || wb !== ewb || rst_req !== erst || {no, zo, co, vo} !== {en, ez, ec, ev}) begin
            bad++;
            $display("FAIL %s op=%h a=%h b=%h: got res=%h wb=%b rst=%b nzcv=%b%b%b%b exp res=%h wb=%b rst=%b nzcv=%b%b%b%b",
                tag_of(op, s, rd), op, a, b, res, wb, rst_req, no, zo, co, vo, er, ewb, erst, en, ez, ec, ev);
        end
    endtask

    task automatic apply(logic [3:0] o, logic [31:0] av, logic [31:0] bv, logic sc,
                         logic [3:0] fl, logic sb, logic [3:0] d, logic [31:0] sv);
        @(posedge clk);
        op = o; a = av; b = bv; shc = sc; {ni, zi, ci, vi} = fl; s = sb; rd = d; saved = sv;
        @(negedge clk);
        check_one();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired, got no finish, expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        op = 0; a = 0; b = 0; shc = 0; {ni, zi, ci, vi} = 0; s = 0; rd = 0; saved = 0;
        // idle state: AND of zeros, S clear (R8 R1)
        apply(4'h0, 0, 0, 0, 4'b0000, 0, 4'h0, 0);
        // R2 carry wrap to zero, and V at the signed limit
        apply(4'h4, 32'hFFFF_FFFF, 32'h1, 0, 4'b0000, 1, 4'h1, 0);
        apply(4'h4, 32'h7FFF_FFFF, 32'h1, 0, 4'b0000, 1, 4'h1, 0);
        // R2 ADC carry only from incoming C
        apply(4'h5, 32'hFFFF_FFFF, 32'h0, 0, 4'b0010, 1, 4'h2, 0);
        // R3 equal operands, SBC all-ones subtrahend, RSB/RSC swap
        apply(4'h2, 32'h1234, 32'h1234, 0, 4'b0000, 1, 4'h3, 0);
        apply(4'h6, 32'h5, 32'hFFFF_FFFF, 0, 4'b0000, 1, 4'h3, 0);
        apply(4'h3, 32'h10, 32'h3, 0, 4'b0000, 1, 4'h3, 0);
        apply(4'h7, 32'h0, 32'h0, 1, 4'b0010, 1, 4'h3, 0);
        // R9 restore on PC destination; R7 compare with PC destination
        apply(4'hD, 32'h0, 32'h0, 1, 4'b0000, 1, 4'hF, 32'hA000_0000);
        apply(4'hA, 32'h1, 32'h2, 0, 4'b0000, 1, 4'hF, 32'hF000_0000);
        // R5 V kept, C from shifter; R7 TST with S clear
        apply(4'hE, 32'hFFFF_0000, 32'h0F0F_0F0F, 1, 4'b0001, 1, 4'h4, 0);
        apply(4'h8, 32'h0, 32'hFFFF_FFFF, 1, 4'b1001, 0, 4'h0, 0);
        for (int k = 0; k < 4000; k++) begin
            apply(4'($urandom % 16),
                  (k % 7 == 0) ? 32'hFFFF_FFFF : $urandom,
                  (k % 5 == 0) ? 32'($urandom % 3) : $urandom,
                  1'($urandom), 4'($urandom), 1'($urandom),
                  ($urandom % 4 == 0) ? 4'hF : 4'($urandom), $urandom);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule